// File: doc/BRIEF.md
# Two-Byte Mailbox I2C Master

This block is a single-master I2C controller that software drives through four 16-bit registers. Software first loads up to two outgoing bytes into a data-out register. It then writes a command word that holds the 7-bit target address, the transfer direction, a one-or-two-byte select and a flag that keeps the bus. Writing an accepted command starts a bus transaction. When the command ends, one of three sticky status bits is set: sent, received or failed. Received bytes are kept in a data-in register.

A command with the keep-bus flag set ends without a STOP. SCL is then left low, and the next command opens with a repeated START. In this way software can chain a register-address write and a data read into a single bus transaction, two bytes at a time. SCL and SDA are open-drain and are driven through active-high pull-low enables. The bit rate comes from a divider parameter. If another device holds SCL low, the controller waits before it continues.

The register port is plain control: one write strobe, an address and a combinational read-back. There is no stream interface, so there are no back-pressure rules.

Top module: `i2c_mbox_master`

## Requirements
- R1: Register map, by `reg_addr`: 0 is the command word, 1 is the data-out word, 2 is the data-in word and 3 is the status word. A command write starts a transaction only when bits 15:14 equal 2. A command with any other mode value is ignored and leaves status, bus and command read-back unchanged.
- R2: In the command word, bits 7:1 hold the target address, bit 10 set means write, and bit 11 set means two data bytes (clear means one). The address byte on the bus is {address, R/W}, and R/W is 1 for a read.
- R3: A write sends data-out bits 7:0 first and then bits 15:8 when two bytes are selected. Each byte is sent MSB first.
- R4: A read places the first received byte in data-in bits 7:0 and the second in bits 15:8. The master ACKs every byte except the last byte of the command, which it NACKs.
- R5: The status word uses bit 15 for received, bit 14 for sent and bit 13 for failed. A write that completes sets bit 14, and a read that completes sets bit 15.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: A NACK on the address byte or on a written data byte ends the command with a STOP and sets only the failed bit.
- R8: With command bit 13 set, the command ends with no STOP and SCL is held low. The next command begins with a repeated START and with no STOP between the two commands.
- R9: A command write while a transaction is running is ignored. Command bits 0, 9:8 and 12 have no effect, and the command read-back shows only the defined fields of the last accepted word.
- R10: When no transaction is running and the bus is not kept, both enables are low. While SCL is released by the master but is seen low, the master does not pull SCL low or advance the bit phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read-back of the selected register |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that the sensed lines are the wired-AND of the master's enables and any target, so a released line reads high unless some other device pulls it low. They also assume that software writes a command only after the previous one has reported a status bit, except in the deliberate busy-write case. The bench keeps to this. Its target model drives SDA and SCL only while SCL is low. Each command is followed by polling until status is non-zero. The single busy-write case is issued on purpose to exercise the ignore rule.

// File: rtl/i2c_mbox_pkg.sv
`timescale 1ns/1ps
package i2c_mbox_pkg;
  localparam int WORD_W = 16;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_DOUT = 2'd1;
  localparam logic [1:0] REG_DIN  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  localparam logic [1:0]        MODE_NATIVE = 2'd2;
  localparam logic [WORD_W-1:0] CMD_KEEP    = 16'hECFE;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BIT} bus_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_START, SQ_ADDR, SQ_AACK, SQ_WBIT, SQ_WACK, SQ_RBIT, SQ_RACK, SQ_STOP
  } seq_state_e;

  typedef struct packed {
    logic [6:0] addr;
    logic       wr;
    logic       two;
    logic       keep;
  } cmd_t;
endpackage

// File: rtl/i2c_mbox_bitphy.sv
`timescale 1ns/1ps
module i2c_mbox_bitphy
  import i2c_mbox_pkg::*;
#(
  parameter int CLK_DIV = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go,
  input  bus_op_e op,
  input  logic    bit_in,
  output logic    take,
  output logic    done,
  output logic    rx_bit,
  input  logic    scl_in,
  input  logic    sda_in,
  output logic    scl_oe,
  output logic    sda_oe
);
  localparam int QDIV = (CLK_DIV / 4 < 2) ? 2 : CLK_DIV / 4;
  localparam int CW   = $clog2(QDIV);

  logic          busy;
  logic [1:0]    q;
  logic [CW-1:0] cnt;
  logic          scl_lvl, sda_lvl;
  bus_op_e       cur_op;
  logic          cur_bit;
  logic          stalled;

  // {scl, sda} released levels for each quarter of a bus operation
  function automatic logic [1:0] lvl(bus_op_e o, logic b, logic [1:0] qq);
    logic [1:0] r;
    case (o)
      OP_START: case (qq)
                  2'd0: r = 2'b01;
                  2'd1: r = 2'b11;
                  2'd2: r = 2'b10;
                  default: r = 2'b00;
                endcase
      OP_STOP:  case (qq)
                  2'd0: r = 2'b00;
                  2'd1: r = 2'b10;
                  default: r = 2'b11;
                endcase
      default:  r = {(qq == 2'd1 || qq == 2'd2), b};
    endcase
    return r;
  endfunction

  assign stalled = scl_lvl && !scl_in;
  assign take    = go && !busy && !stalled;
  assign scl_oe  = !scl_lvl;
  assign sda_oe  = !sda_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      q       <= '0;
      cnt     <= '0;
      scl_lvl <= 1'b1;
      sda_lvl <= 1'b1;
      cur_op  <= OP_STOP;
      cur_bit <= 1'b1;
      done    <= 1'b0;
      rx_bit  <= 1'b1;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy               <= 1'b1;
        q                  <= '0;
        cnt                <= '0;
        cur_op             <= op;
        cur_bit            <= bit_in;
        {scl_lvl, sda_lvl} <= lvl(op, bit_in, 2'd0);
      end else if (busy && !stalled) begin
        if (cnt == CW'(QDIV - 1)) begin
          cnt <= '0;
          if (q == 2'd1) rx_bit <= sda_in;
          if (q == 2'd3) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            q                  <= q + 2'd1;
            {scl_lvl, sda_lvl} <= lvl(cur_op, cur_bit, q + 2'd1);
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mbox_seq.sv
`timescale 1ns/1ps
module i2c_mbox_seq
  import i2c_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_t              cmd,
  input  logic [WORD_W-1:0] dout,
  output logic              busy,
  output logic              held,
  output logic              ok_pulse,
  output logic              err_pulse,
  output logic              was_wr,
  output logic [WORD_W-1:0] rd_word,
  output logic              go,
  output bus_op_e           op,
  output logic              bit_o,
  input  logic              take,
  input  logic              done,
  input  logic              rx_bit
);
  seq_state_e        state;
  cmd_t              cur;
  logic [WORD_W-1:0] data;
  logic [7:0]        sh;
  logic [2:0]        bcnt;
  logic              bidx;
  logic              issued;
  logic              err_f;
  logic              last_byte;

  assign busy      = (state != SQ_IDLE);
  assign was_wr    = cur.wr;
  assign last_byte = bidx || !cur.two;
  assign go        = busy && !issued;

  always_comb begin
    op    = OP_BIT;
    bit_o = 1'b1;
    case (state)
      SQ_START:         op = OP_START;
      SQ_STOP:          op = OP_STOP;
      SQ_ADDR, SQ_WBIT: bit_o = sh[7];
      SQ_RACK:          bit_o = last_byte;
      default:          bit_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      cur       <= '0;
      data      <= '0;
      sh        <= '0;
      bcnt      <= '0;
      bidx      <= 1'b0;
      issued    <= 1'b0;
      err_f     <= 1'b0;
      held      <= 1'b0;
      ok_pulse  <= 1'b0;
      err_pulse <= 1'b0;
      rd_word   <= '0;
    end else begin
      ok_pulse  <= 1'b0;
      err_pulse <= 1'b0;
      if (take) issued <= 1'b1;
      if (state == SQ_IDLE) begin
        if (start) begin
          cur    <= cmd;
          data   <= dout;
          err_f  <= 1'b0;
          issued <= 1'b0;
          state  <= SQ_START;
        end
      end else if (done) begin
        issued <= 1'b0;
        case (state)
          SQ_START: begin
            sh    <= {cur.addr, !cur.wr};
            bcnt  <= '0;
            state <= SQ_ADDR;
          end
          SQ_ADDR, SQ_WBIT: begin
            sh <= {sh[6:0], 1'b0};
            if (bcnt == 3'd7) state <= (state == SQ_ADDR) ? SQ_AACK : SQ_WACK;
            else bcnt <= bcnt + 3'd1;
          end
          SQ_AACK: begin
            bidx <= 1'b0;
            bcnt <= '0;
            if (rx_bit) begin
              err_f <= 1'b1;
              state <= SQ_STOP;
            end else if (cur.wr) begin
              sh    <= data[7:0];
              state <= SQ_WBIT;
            end else begin
              state <= SQ_RBIT;
            end
          end
          SQ_WACK: begin
            if (rx_bit) begin
              err_f <= 1'b1;
              state <= SQ_STOP;
            end else if (!last_byte) begin
              bidx  <= 1'b1;
              bcnt  <= '0;
              sh    <= data[15:8];
              state <= SQ_WBIT;
            end else if (cur.keep) begin
              held     <= 1'b1;
              ok_pulse <= 1'b1;
              state    <= SQ_IDLE;
            end else begin
              state <= SQ_STOP;
            end
          end
          SQ_RBIT: begin
            sh <= {sh[6:0], rx_bit};
            if (bcnt == 3'd7) begin
              if (bidx) rd_word[15:8] <= {sh[6:0], rx_bit};
              else      rd_word[7:0]  <= {sh[6:0], rx_bit};
              state <= SQ_RACK;
            end else begin
              bcnt <= bcnt + 3'd1;
            end
          end
          SQ_RACK: begin
            if (!last_byte) begin
              bidx  <= 1'b1;
              bcnt  <= '0;
              state <= SQ_RBIT;
            end else if (cur.keep) begin
              held     <= 1'b1;
              ok_pulse <= 1'b1;
              state    <= SQ_IDLE;
            end else begin
              state <= SQ_STOP;
            end
          end
          SQ_STOP: begin
            held      <= 1'b0;
            ok_pulse  <= !err_f;
            err_pulse <= err_f;
            state     <= SQ_IDLE;
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mbox_master.sv
`timescale 1ns/1ps
module i2c_mbox_master
  import i2c_mbox_pkg::*;
#(
  parameter int CLK_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [WORD_W-1:0] cmd_q, dout_q, rd_word;
  logic [2:0]        stat_q;   // {received, sent, failed}
  logic [2:0]        stat_set, stat_clr;
  logic              cmd_wr, cmd_fire;
  logic              seq_busy, seq_held, ok_pulse, err_pulse, was_wr;
  logic              go, take, done, rx_bit, bit_o;
  bus_op_e           op;
  cmd_t              new_cmd;

  assign cmd_wr   = reg_wr && (reg_addr == REG_CMD);
  assign cmd_fire = cmd_wr && !seq_busy && (reg_wdata[15:14] == MODE_NATIVE);
  assign new_cmd  = '{addr: reg_wdata[7:1], wr: reg_wdata[10],
                      two: reg_wdata[11], keep: reg_wdata[13]};

  assign stat_set = {ok_pulse && !was_wr, ok_pulse && was_wr, err_pulse};
  assign stat_clr = (reg_wr && reg_addr == REG_STAT) ? reg_wdata[15:13] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      dout_q <= '0;
      stat_q <= '0;
    end else begin
      if (cmd_fire) cmd_q <= reg_wdata & CMD_KEEP;
      if (reg_wr && reg_addr == REG_DOUT) dout_q <= reg_wdata;
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CMD:  reg_rdata = cmd_q;
      REG_DOUT: reg_rdata = dout_q;
      REG_DIN:  reg_rdata = rd_word;
      default:  reg_rdata = {stat_q, 13'b0};
    endcase
  end

  i2c_mbox_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_fire), .cmd(new_cmd), .dout(dout_q),
    .busy(seq_busy), .held(seq_held), .ok_pulse(ok_pulse), .err_pulse(err_pulse),
    .was_wr(was_wr), .rd_word(rd_word), .go(go), .op(op), .bit_o(bit_o),
    .take(take), .done(done), .rx_bit(rx_bit)
  );

  i2c_mbox_bitphy #(.CLK_DIV(CLK_DIV)) u_phy (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .bit_in(bit_o), .take(take),
    .done(done), .rx_bit(rx_bit), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2c_mbox_checker.sv
`timescale 1ns/1ps
module i2c_mbox_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        scl_in,
  input logic        busy,
  input logic        held,
  input logic        cmd_wr_busy,
  input logic [15:0] cmd_q,
  input logic [2:0]  stat_q
);
  assert_idle_bus_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !held) |-> (!scl_oe && !sda_oe));

  assert_kept_bus_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && held) |-> scl_oe);

  assert_stretch_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !scl_in) |=> !scl_oe);

  assert_busy_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_busy |=> $stable(cmd_q));

  assert_fail_excludes_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[0]) |-> !($rose(stat_q[1]) || $rose(stat_q[2])));
endmodule

bind i2c_mbox_master i2c_mbox_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in),
  .busy(seq_busy), .held(seq_held), .cmd_wr_busy(cmd_wr && seq_busy),
  .cmd_q(cmd_q), .stat_q(stat_q)
);

// File: tb/test_i2c_mbox_master.sv
`timescale 1ns/1ps
module test_i2c_mbox_master;
  localparam logic [6:0] SLV = 7'h50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        scl_oe, sda_oe;
  logic        s_scl_low = 1'b0, s_sda_low = 1'b0;
  wire         scl_bus = !(scl_oe || s_scl_low);
  wire         sda_bus = !(sda_oe || s_sda_low);

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  logic [7:0] exp_wr[$];
  logic [7:0] rd_src[$];
  logic       ack_log[$];
  int start_cnt = 0, stop_cnt = 0, stretch_cycles = 0, stretch_events = 0;
  int nack_byte = -1, wbyte_idx = 0;

  always #2 clk = ~clk;

  i2c_mbox_master #(.CLK_DIV(16)) i_i2c_mbox_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_bus),
    .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard compare of a byte seen on the bus against the driver's queue
  task automatic compare_byte(logic [7:0] b);
    if (exp_wr.size() == 0) check({cur_req, " unexpected bus byte"}, {24'd0, b}, 32'hFFFF_FFFF);
    else check({cur_req, " bus byte"}, {24'd0, b}, {24'd0, exp_wr.pop_front()});
  endtask

  // target model: address 0x50, MSB first, optional SCL stretch and data NACK
  logic       prev_scl = 1'b1, prev_sda = 1'b1, t_scl, t_sda;
  int         mode = 0, bc = 0, stretch_left = 0;
  logic [7:0] sh = '0, tx = '0;
  logic       rw = 1'b0, skip = 1'b0, mack = 1'b0;

  always @(posedge clk) begin
    t_scl = scl_bus;
    t_sda = sda_bus;
    if (stretch_left > 0) begin
      stretch_left--;
      if (stretch_left == 0) s_scl_low <= 1'b0;
    end
    if (prev_scl && t_scl && prev_sda && !t_sda) begin
      start_cnt++; mode = 1; bc = 0; skip = 1'b1; wbyte_idx = 0; s_sda_low <= 1'b0;
    end else if (prev_scl && t_scl && !prev_sda && t_sda) begin
      stop_cnt++; mode = 0; s_sda_low <= 1'b0;
    end else if (!prev_scl && t_scl) begin
      if (bc < 8 && (mode == 1 || mode == 2)) sh = {sh[6:0], t_sda};
      if (bc == 8 && mode == 3) mack = !t_sda;
    end else if (prev_scl && !t_scl && mode != 0) begin
      if (skip) skip = 1'b0;
      else begin
        if (stretch_cycles > 0) begin
          s_scl_low <= 1'b1; stretch_left = stretch_cycles; stretch_events++;
        end
        bc++;
        if (bc == 8) begin
          if (mode == 1) begin
            rw = sh[0];
            compare_byte(sh);
            if (sh[7:1] == SLV) s_sda_low <= 1'b1;
            else mode = 0;
          end else if (mode == 2) begin
            compare_byte(sh);
            s_sda_low <= (wbyte_idx != nack_byte);
            wbyte_idx++;
          end else s_sda_low <= 1'b0;
        end else if (bc == 9) begin
          bc = 0;
          if (mode == 1) begin
            if (rw) begin
              mode = 3;
              tx = (rd_src.size() > 0) ? rd_src.pop_front() : 8'hFF;
              s_sda_low <= !tx[7];
            end else begin
              mode = 2; s_sda_low <= 1'b0;
            end
          end else if (mode == 2) s_sda_low <= 1'b0;
          else begin
            ack_log.push_back(mack);
            if (mack) begin
              tx = (rd_src.size() > 0) ? rd_src.pop_front() : 8'hFF;
              s_sda_low <= !tx[7];
            end else begin
              mode = 0; s_sda_low <= 1'b0;
            end
          end
        end else if (mode == 3) s_sda_low <= !tx[7-bc];
      end
    end
    prev_scl = t_scl;
    prev_sda = t_sda;
  end

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_status(output logic [15:0] s);
    s = '0;
    for (int i = 0; i < 4000 && s == 16'h0; i++) reg_read(2'd3, s);
  endtask

  // driver: push the bytes the target must see, then issue the command
  task automatic drive_cmd(logic [15:0] w, logic [7:0] b0, int n, logic [7:0] b1, logic [7:0] b2);
    exp_wr.push_back(b0);
    if (n > 1) exp_wr.push_back(b1);
    if (n > 2) exp_wr.push_back(b2);
    reg_write(2'd0, w);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int s0, p0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    reg_read(2'd3, v); check("R5 reset status", v, 16'h0000);
    reg_read(2'd0, v); check("R1 reset cmd", v, 16'h0000);
    reg_read(2'd2, v); check("R4 reset data-in", v, 16'h0000);
    check("R10 reset lines", {scl_oe, sda_oe}, 2'b00);

    // single-byte write
    cur_req = "R2";
    reg_write(2'd1, 16'h00A5);
    s0 = start_cnt; p0 = stop_cnt;
    drive_cmd(16'h84A0, 8'hA0, 2, 8'hA5, 8'h00);
    wait_status(v);
    check("R5 write sets sent", v, 16'h4000);
    check("R2 one start", start_cnt - s0, 1);
    check("R2 one stop", stop_cnt - p0, 1);
    check("R10 idle lines", {scl_oe, sda_oe}, 2'b00);

    // write-one-to-clear
    reg_write(2'd3, 16'h0000); reg_read(2'd3, v); check("R6 zero keeps", v, 16'h4000);
    reg_write(2'd3, 16'hA000); reg_read(2'd3, v); check("R6 other bits keep", v, 16'h4000);
    reg_write(2'd3, 16'h4000); reg_read(2'd3, v); check("R6 one clears", v, 16'h0000);

    // two-byte write order
    cur_req = "R3";
    reg_write(2'd1, 16'hC33C);
    drive_cmd(16'h8CA0, 8'hA0, 3, 8'h3C, 8'hC3);
    wait_status(v);
    check("R3 two-byte write sent", v, 16'h4000);
    reg_write(2'd3, 16'hE000);

    // two-byte read
    cur_req = "R4";
    ack_log.delete();
    rd_src.push_back(8'h12); rd_src.push_back(8'h34);
    drive_cmd(16'h88A0, 8'hA1, 1, 8'h00, 8'h00);
    wait_status(v);
    check("R5 read sets received", v, 16'h8000);
    reg_read(2'd2, v); check("R4 byte order", v, 16'h3412);
    check("R4 ack count", ack_log.size(), 2);
    if (ack_log.size() == 2) begin
      check("R4 first byte ACK", ack_log[0], 1'b1);
      check("R4 last byte NACK", ack_log[1], 1'b0);
    end
    reg_write(2'd3, 16'hE000);

    // one-byte read
    ack_log.delete();
    rd_src.push_back(8'h9E);
    drive_cmd(16'h80A0, 8'hA1, 1, 8'h00, 8'h00);
    wait_status(v);
    check("R4 one-byte read status", v, 16'h8000);
    reg_read(2'd2, v); check("R4 one-byte low lane", v[7:0], 8'h9E);
    check("R4 single NACK", ack_log.size() == 1 && ack_log[0] == 1'b0, 1'b1);
    reg_write(2'd3, 16'hE000);

    // address NACK
    cur_req = "R7";
    s0 = stop_cnt;
    drive_cmd(16'h8422, 8'h22, 1, 8'h00, 8'h00);
    wait_status(v);
    check("R7 address NACK fails only", v, 16'h2000);
    check("R7 address NACK stop", stop_cnt - s0, 1);
    check("R7 lines free", {scl_oe, sda_oe}, 2'b00);
    reg_write(2'd3, 16'hE000);

    // data NACK on first byte: second byte must not appear
    nack_byte = 0;
    reg_write(2'd1, 16'h5566);
    drive_cmd(16'h8CA0, 8'hA0, 2, 8'h66, 8'h00);
    wait_status(v);
    check("R7 data NACK fails only", v, 16'h2000);
    nack_byte = -1;
    reg_write(2'd3, 16'hE000);

    // keep bus, then repeated START into a read
    cur_req = "R8";
    s0 = start_cnt; p0 = stop_cnt;
    reg_write(2'd1, 16'h0077);
    drive_cmd(16'hA4A0, 8'hA0, 2, 8'h77, 8'h00);
    wait_status(v);
    check("R8 kept write sent", v, 16'h4000);
    check("R8 no stop", stop_cnt - p0, 0);
    check("R8 scl held low", scl_oe, 1'b1);
    reg_write(2'd3, 16'hE000);
    rd_src.push_back(8'h5A);
    drive_cmd(16'h80A0, 8'hA1, 1, 8'h00, 8'h00);
    wait_status(v);
    check("R8 read after repeated start", v, 16'h8000);
    check("R8 two starts", start_cnt - s0, 2);
    check("R8 one stop", stop_cnt - p0, 1);
    reg_read(2'd2, v); check("R8 read data", v[7:0], 8'h5A);
    reg_write(2'd3, 16'hE000);

    // reserved bits ignored, command while busy ignored
    cur_req = "R9";
    reg_write(2'd1, 16'h0011);
    drive_cmd(16'h97A1, 8'hA0, 2, 8'h11, 8'h00);
    reg_write(2'd0, 16'h84C4);
    reg_read(2'd0, v); check("R9 busy write ignored", v, 16'h84A0);
    wait_status(v);
    check("R9 reserved bits ignored", v, 16'h4000);
    reg_write(2'd3, 16'hE000);

    // non-native mode ignored
    cur_req = "R1";
    s0 = start_cnt;
    reg_write(2'd0, 16'h44A0);
    repeat (300) @(negedge clk);
    reg_read(2'd3, v); check("R1 wrong mode no status", v, 16'h0000);
    reg_read(2'd0, v); check("R1 wrong mode cmd kept", v, 16'h84A0);
    check("R1 wrong mode no start", start_cnt - s0, 0);

    // clock stretching by the target
    cur_req = "R10";
    stretch_cycles = 30; stretch_events = 0;
    reg_write(2'd1, 16'h00E7);
    drive_cmd(16'h84A0, 8'hA0, 2, 8'hE7, 8'h00);
    wait_status(v);
    stretch_cycles = 0;
    check("R10 stretched write sent", v, 16'h4000);
    check("R10 stretch seen", stretch_events > 0, 1'b1);
    repeat (40) @(negedge clk);
    check("R10 lines free after stretch", {scl_oe, sda_oe}, 2'b00);

    check("R3 scoreboard drained", exp_wr.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule